// File: doc/BRIEF.md
# Flash Status Register with Write-Protect Gating

This block holds the eight-bit status register of a serial flash device and decides whether each write-status command may change it. The command decoder presents a one-cycle strobe with a data byte. The block checks that strobe against three things: the active-low write-protect pin, the stored lock-down bit and the internal busy flag. If the command is allowed, the block loads the writable fields. For every strobe it returns a one-cycle accepted or rejected pulse.

Only the three block-protect bits and the lock-down bit live in this block. The busy, write-enable latch, security-lock and auto-increment bits come from elsewhere in the device. They are merged into the status byte without change, so a status read always shows their current value and a write-status command can never alter them. When the lock-down bit is set and the pin is driven low, the protect bits cannot be changed. When the pin is high, the lock-down bit has no effect on whether a write is allowed.

Top module: `flash_status_reg`

## Requirements
- R1: The status byte is laid out as bit 0 busy, bit 1 write-enable latch, bits 2..4 block-protect bits 0..2, bit 5 security-lock, bit 6 auto-increment mode, and bit 7 lock-down.
- R2: After synchronous reset, the block-protect bits read 1, the lock-down bit reads 0, and neither the accept pulse nor the reject pulse is asserted. With all status inputs low, the status byte is 8'h1C.
- R3: A write-status strobe taken while the pin is low and the lock-down bit is 1 is rejected, and the stored bits stay unchanged.
- R4: A write-status strobe taken while the pin is low and the lock-down bit is 0 is accepted.
- R5: While the pin is high, a write-status strobe is accepted whatever the lock-down bit holds. This includes a write that clears the lock-down bit.
- R6: Bits 0, 1, 5 and 6 of the status byte always follow the busy, write-enable, security-lock and auto-increment inputs. The data byte of a write-status command never changes them.
- R7: A write-status strobe taken while busy is high is rejected, whatever the state of the pin and the lock-down bit, and the stored bits stay unchanged.
- R8: An accepted strobe loads data bits 2, 3, 4 and 7 into the register at the same clock edge that samples the strobe. The new value shows on the status byte right after that edge.
- R9: Each strobe produces exactly one one-cycle pulse, on either the accept output or the reject output, after the edge that samples it. No pulse occurs without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| wp_n | input | 1 | Write-protect pin, active low |
| wrsr_stb | input | 1 | One-cycle write-status command strobe |
| wrsr_data | input | 8 | Data byte of the write-status command |
| busy_in | input | 1 | Internal erase/program in progress |
| wel_in | input | 1 | Write-enable latch state |
| aai_in | input | 1 | Auto-increment programming mode active |
| sec_lock_in | input | 1 | Security-ID space locked |
| status_q | output | 8 | Status byte for status reads |
| wrsr_accept | output | 1 | One-cycle pulse: command applied |
| wrsr_reject | output | 1 | One-cycle pulse: command refused |

## Verification
The bench builds the block with its default parameters: three block-protect bits that reset to all ones. This makes every field of the byte reachable, including the 8'h1C reset value. Directed scenarios walk through all four combinations of pin and lock-down bit, busy blocking, data bytes that try to set the read-only fields, and back-to-back strobes. Together these cover every branch of the gating decision and the exclusive pulse pair.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam int SR_W      = 8;
    localparam int PROT_N    = 3;
    localparam int BUSY_POS  = 0;
    localparam int WEL_POS   = 1;
    localparam int PROT_LO   = 2;
    localparam int SEC_POS   = 5;
    localparam int AAI_POS   = 6;
    localparam int LOCK_POS  = 7;

    typedef struct packed {
        logic              lock;
        logic [PROT_N-1:0] prot;
    } prot_state_t;

    typedef struct packed {
        logic busy;
        logic wel;
        logic sec;
        logic aai;
    } ext_flags_t;

    function automatic logic wrsr_allowed(input logic wp_n,
                                          input logic lock,
                                          input logic busy);
        return !busy && (wp_n || !lock);
    endfunction

    function automatic prot_state_t unpack_byte(input logic [SR_W-1:0] b);
        prot_state_t s;
        s.lock = b[LOCK_POS];
        s.prot = b[PROT_LO +: PROT_N];
        return s;
    endfunction

endpackage

// File: rtl/flash_sr_gate.sv
module flash_sr_gate
    import flash_sr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic wp_n,
    input  logic lock,
    input  logic busy,
    output logic load,
    output logic accept_q,
    output logic reject_q
);

    logic ok;

    always_comb begin
        ok   = wrsr_allowed(wp_n, lock, busy);
        load = stb && ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_q <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            accept_q <= stb && ok;
            reject_q <= stb && !ok;
        end
    end

    p_busy_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (stb && busy) |=> reject_q);

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(accept_q && reject_q));

    p_no_stray_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        !stb |=> (!accept_q && !reject_q));

    p_pulse_per_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        stb |=> (accept_q || reject_q));

endmodule

// File: rtl/flash_sr_prot_reg.sv
module flash_sr_prot_reg
    import flash_sr_pkg::*;
#(
    parameter logic [PROT_N-1:0] PROT_RESET = '1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SR_W-1:0]   data,
    output prot_state_t       state_q
);

    prot_state_t nxt;

    always_comb begin
        nxt = load ? unpack_byte(data) : state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.lock <= 1'b0;
            state_q.prot <= PROT_RESET;
        end else begin
            state_q <= nxt;
        end
    end

    p_hold_without_load_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(state_q));

endmodule

// File: rtl/flash_sr_compose.sv
module flash_sr_compose
    import flash_sr_pkg::*;
(
    input  prot_state_t     state,
    input  ext_flags_t      flags,
    output logic [SR_W-1:0] status
);

    always_comb begin
        status           = '0;
        status[BUSY_POS] = flags.busy;
        status[WEL_POS]  = flags.wel;
        status[SEC_POS]  = flags.sec;
        status[AAI_POS]  = flags.aai;
        status[LOCK_POS] = state.lock;
    end

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_sr_pkg::*;
#(
    parameter logic [PROT_N-1:0] PROT_RESET = '1
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            wp_n,
    input  logic            wrsr_stb,
    input  logic [SR_W-1:0] wrsr_data,
    input  logic            busy_in,
    input  logic            wel_in,
    input  logic            aai_in,
    input  logic            sec_lock_in,
    output logic [SR_W-1:0] status_q,
    output logic            wrsr_accept,
    output logic            wrsr_reject
);

    prot_state_t     st;
    ext_flags_t      flags;
    logic            load;
    logic [SR_W-1:0] base;

    always_comb begin
        flags.busy = busy_in;
        flags.wel  = wel_in;
        flags.sec  = sec_lock_in;
        flags.aai  = aai_in;
    end

    flash_sr_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .stb      (wrsr_stb),
        .wp_n     (wp_n),
        .lock     (st.lock),
        .busy     (busy_in),
        .load     (load),
        .accept_q (wrsr_accept),
        .reject_q (wrsr_reject)
    );

    flash_sr_prot_reg #(.PROT_RESET(PROT_RESET)) u_prot (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .data    (wrsr_data),
        .state_q (st)
    );

    flash_sr_compose u_comp (
        .state  (st),
        .flags  (flags),
        .status (base)
    );

    // Block-protect bits placed by generate, one per field position
    genvar gi;
    generate
        for (gi = 0; gi < SR_W; gi++) begin : g_bits
            if (gi >= PROT_LO && gi < PROT_LO + PROT_N) begin : g_prot
                assign status_q[gi] = st.prot[gi-PROT_LO];
            end else begin : g_pass
                assign status_q[gi] = base[gi];
            end
        end
    endgenerate

    p_reject_holds_r3: assert property (@(posedge clk) disable iff (rst)
        wrsr_reject |-> (st == $past(st)));

    p_locked_reject_r3: assert property (@(posedge clk) disable iff (rst)
        (wrsr_stb && !wp_n && st.lock) |=> wrsr_reject);

    p_unlocked_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (wrsr_stb && !busy_in && !wp_n && !st.lock) |=> wrsr_accept);

    p_pin_high_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (wrsr_stb && !busy_in && wp_n) |=> wrsr_accept);

    p_accept_loads_r8: assert property (@(posedge clk) disable iff (rst)
        wrsr_accept |-> (status_q[LOCK_POS] == $past(wrsr_data[LOCK_POS]) &&
                         status_q[PROT_LO +: PROT_N] == $past(wrsr_data[PROT_LO +: PROT_N])));

    p_readonly_follow_r6: assert property (@(posedge clk) disable iff (rst)
        status_q[BUSY_POS] == busy_in && status_q[WEL_POS] == wel_in &&
        status_q[SEC_POS] == sec_lock_in && status_q[AAI_POS] == aai_in);

endmodule

// File: tb/flash_status_reg_tb_top.sv
module flash_status_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wp_n = 1'b1;
    logic       wrsr_stb = 1'b0;
    logic [7:0] wrsr_data = 8'h00;
    logic       busy_in = 1'b0;
    logic       wel_in = 1'b0;
    logic       aai_in = 1'b0;
    logic       sec_lock_in = 1'b0;
    logic [7:0] status_q;
    logic       wrsr_accept;
    logic       wrsr_reject;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_status_reg dut_i (
        .clk(clk), .rst(rst), .wp_n(wp_n), .wrsr_stb(wrsr_stb),
        .wrsr_data(wrsr_data), .busy_in(busy_in), .wel_in(wel_in),
        .aai_in(aai_in), .sec_lock_in(sec_lock_in), .status_q(status_q),
        .wrsr_accept(wrsr_accept), .wrsr_reject(wrsr_reject)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Pulses packed as {accept, reject}
    task automatic strobe(input logic [7:0] d, output logic [1:0] pulse);
        @(negedge clk);
        wrsr_stb  = 1'b1;
        wrsr_data = d;
        @(negedge clk);
        wrsr_stb  = 1'b0;
        pulse = {wrsr_accept, wrsr_reject};
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R2 status", status_q, 8'h1C);
        chk("R2 pulses", {6'd0, wrsr_accept, wrsr_reject}, 8'h00);
    endtask

    task automatic t_layout;
        @(negedge clk); busy_in = 1'b1; #0.5 chk("R1 busy bit", status_q, 8'h1D);
        busy_in = 1'b0; wel_in = 1'b1; #0.5 chk("R1 wel bit", status_q, 8'h1E);
        wel_in = 1'b0; sec_lock_in = 1'b1; #0.5 chk("R1 sec bit", status_q, 8'h3C);
        sec_lock_in = 1'b0; aai_in = 1'b1; #0.5 chk("R1 aai bit", status_q, 8'h5C);
        aai_in = 1'b0;
    endtask

    task automatic t_pin_high;
        logic [1:0] p;
        wp_n = 1'b1;
        strobe(8'h80, p);
        chk("R5 accept", {6'd0, p}, 8'h02);
        chk("R8 load lock", status_q, 8'h80);
        strobe(8'h94, p);
        chk("R5 accept while locked", {6'd0, p}, 8'h02);
        chk("R8 load 94", status_q, 8'h94);
        strobe(8'h00, p);
        chk("R5 clear lock", status_q, 8'h00);
    endtask

    task automatic t_pin_low;
        logic [1:0] p;
        wp_n = 1'b0;
        strobe(8'h8C, p);
        chk("R4 accept", {6'd0, p}, 8'h02);
        chk("R4 status", status_q, 8'h8C);
        strobe(8'h10, p);
        chk("R3 reject", {6'd0, p}, 8'h01);
        chk("R3 unchanged", status_q, 8'h8C);
        wp_n = 1'b1;
        strobe(8'h18, p);
        chk("R5 unlock via pin", status_q, 8'h18);
    endtask

    task automatic t_readonly;
        logic [1:0] p;
        wp_n = 1'b1;
        strobe(8'hFF, p);
        chk("R6 write FF", status_q, 8'h9C);
        strobe(8'h63, p);
        chk("R6 write 63", status_q, 8'h00);
        wel_in = 1'b1; sec_lock_in = 1'b1;
        strobe(8'h00, p);
        chk("R6 inputs shown", status_q, 8'h22);
        wel_in = 1'b0; sec_lock_in = 1'b0;
    endtask

    task automatic t_busy;
        logic [1:0] p;
        wp_n = 1'b1;
        busy_in = 1'b1;
        strobe(8'h10, p);
        chk("R7 reject", {6'd0, p}, 8'h01);
        chk("R7 unchanged", status_q, 8'h01);
        busy_in = 1'b0;
        strobe(8'h10, p);
        chk("R7 accept after busy", status_q, 8'h10);
    endtask

    task automatic t_pulses;
        @(negedge clk);
        chk("R9 idle 1", {6'd0, wrsr_accept, wrsr_reject}, 8'h00);
        wp_n = 1'b0; wrsr_data = 8'h84; wrsr_stb = 1'b1;
        @(negedge clk);
        chk("R9 first pulse", {6'd0, wrsr_accept, wrsr_reject}, 8'h02);
        wrsr_data = 8'h00;
        @(negedge clk);
        wrsr_stb = 1'b0;
        chk("R9 second pulse rejected", {6'd0, wrsr_accept, wrsr_reject}, 8'h01);
        chk("R3 still locked", status_q, 8'h84);
        @(negedge clk);
        chk("R9 pulse ends", {6'd0, wrsr_accept, wrsr_reject}, 8'h00);
        wp_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_layout;
        t_pin_high;
        t_pin_low;
        t_readonly;
        t_busy;
        t_pulses;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule